// File: doc/BRIEF.md
# Backlight PWM Generator with Power-of-Two Prescaler

This block produces a single pulse-width-modulated output, intended to drive a display backlight through an external low-pass filter. The whole design runs on one clock. Two source rates reach it as one-cycle enable pulses: a slow enable and a system enable. A clock-select register picks one of them. The selected enable goes through a power-of-two prescaler, and each prescaled tick advances a free-running 8-bit count. The period is therefore always 256 ticks. The output is formed by comparing the count against a programmable compare value. A polarity bit chooses whether the pulse is driven high or low.

Software programs the block with single-cycle writes. A write with `wr_sel` low carries the configuration word: compare value, polarity and prescale exponent. A write with `wr_sel` high carries the clock-select bit. The configuration word is held in a shadow register. It only reaches the comparator when the count wraps from 255 to 0, so a rewrite in the middle of a period never produces a runt pulse. A one-cycle strobe marks the start of every period.

Top module: `bl_pwm_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `pwm_out` is 1 and `period_start` is 0. Reset sets the active compare value to 0, polarity to 0, prescale to 0, the count to 0 and the clock source to slow.
- R2: One period lasts exactly 256 prescaled ticks, so with the system enable held high and prescale N it lasts 256·2^N clock cycles.
- R3: With polarity 1, `pwm_out` is high exactly while the count is below the compare value. Per period it is high for compare·2^N ticks' worth of cycles. Compare 0 gives no high cycle, and compare 255 is the widest pulse, so a full-period pulse never occurs.
- R4: With polarity 0, `pwm_out` is the complement of the polarity-1 waveform, giving (256 − compare)·2^N high cycles per period.
- R5: A configuration write (`wr_en`=1, `wr_sel`=0) takes the compare value from `wr_data[15:8]`, the polarity from `wr_data[4]` and the prescale exponent from `wr_data[2:0]`. Bits 7:5 and 3 have no effect.
- R6: A prescale exponent N from 0 to 6 divides the selected enable rate by 2^N.
- R7: A prescale exponent of 7 behaves exactly like 6.
- R8: A clock-select write (`wr_en`=1, `wr_sel`=1) takes `wr_data[0]`: 0 counts slow-enable pulses and 1 counts system-enable pulses.
- R9: A configuration write has no effect on the waveform until the next wrap from 255 to 0. The first full period after that wrap uses the new settings.
- R10: `period_start` is high for exactly one cycle per period. That cycle is the first cycle in which the count is 0 after a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_en | input | 1 | One-cycle pulse at the slow source rate |
| sys_en | input | 1 | One-cycle pulse at the system source rate |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: configuration word, 1: clock-select |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | Pulse-width-modulated output |
| period_start | output | 1 | One-cycle strobe at the start of each period |

## Verification
A write sampled at one edge lands in the shadow register at that edge. It reaches the comparator only at the wrap edge. At that same wrap edge the count becomes 0 and `period_start` rises. `pwm_out` is decoded directly from the count and active registers, so it changes in the same cycle as the count does. The bench therefore drives and samples on the falling edge. It treats the first cycle with `period_start` high as position 0 of the new settings. It counts high cycles of `pwm_out` and the cycles up to the next strobe, and compares both against 256·2^N and compare·2^N (or its complement), computed arithmetically. For the shadow check it writes a new compare value in the middle of a period. It confirms the remaining cycles of that period still follow the old value, and that the following period follows the new one.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

    localparam int CNT_W   = 8;           // PWM count width, period = 2**CNT_W
    localparam int PS_W    = 3;           // prescale exponent field width
    localparam int PS_MAX  = 6;           // largest usable exponent
    localparam int PRE_W   = PS_MAX;      // prescale counter width
    localparam int CFG_W   = 16;          // write data width
    localparam int CV_LSB  = 8;           // compare value position
    localparam int POL_BIT = 4;           // polarity bit position

    typedef enum logic {
        SRC_SLOW = 1'b0,
        SRC_SYS  = 1'b1
    } src_sel_t;

    typedef struct packed {
        logic [CNT_W-1:0] cval;
        logic             pol;
        logic [PS_W-1:0]  psc;
    } pwm_cfg_t;

    localparam pwm_cfg_t CFG_RESET = '{cval: '0, pol: 1'b0, psc: '0};

    function automatic pwm_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        pwm_cfg_t c;
        c.cval = w[CV_LSB +: CNT_W];
        c.pol  = w[POL_BIT];
        if (w[PS_W-1:0] > PS_W'(PS_MAX))
            c.psc = PS_W'(PS_MAX);
        else
            c.psc = w[PS_W-1:0];
        return c;
    endfunction

    function automatic logic [PRE_W-1:0] div_mask(input logic [PS_W-1:0] n);
        logic [PRE_W-1:0] m;
        for (int i = 0; i < PRE_W; i++)
            m[i] = (i < int'(n));
        return m;
    endfunction

endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
    import bl_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             wrap,
    output pwm_cfg_t         act_cfg,
    output src_sel_t         src_sel
);

    pwm_cfg_t shadow_q;
    pwm_cfg_t act_q;
    src_sel_t src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= CFG_RESET;
            src_q    <= SRC_SLOW;
        end else if (wr_en) begin
            if (wr_sel)
                src_q <= src_sel_t'(wr_data[0]);
            else
                shadow_q <= unpack_cfg(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            act_q <= CFG_RESET;
        else if (wrap)
            act_q <= shadow_q;
    end

    assign act_cfg = act_q;
    assign src_sel = src_q;

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(act_q));

    // R7
    psc_sat_chk: assert property (@(posedge clk) disable iff (rst)
        act_q.psc <= PS_W'(PS_MAX));

endmodule

// File: rtl/bl_pwm_prescaler.sv
module bl_pwm_prescaler
    import bl_pwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            slow_en,
    input  logic            sys_en,
    input  src_sel_t        src_sel,
    input  logic [PS_W-1:0] psc,
    input  logic            wrap,
    output logic            step
);

    logic             tick;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        case (src_sel)
            SRC_SYS: tick = sys_en;
            default: tick = slow_en;
        endcase
    end

    assign mask = div_mask(psc);
    assign step = tick && ((pre_q & mask) == mask);

    // restart the divider on every wrap so each period begins aligned
    always_ff @(posedge clk) begin
        if (rst || wrap)
            pre_q <= '0;
        else if (tick)
            pre_q <= pre_q + PRE_W'(1);
    end

    // R8
    step_src_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> ((src_sel == SRC_SYS) ? sys_en : slow_en));

endmodule

// File: rtl/bl_pwm_counter.sv
module bl_pwm_counter
    import bl_pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     step,
    input  pwm_cfg_t act_cfg,
    output logic     wrap,
    output logic     pwm_out,
    output logic     period_start
);

    logic [CNT_W-1:0] cnt_q;
    logic             strobe_q;
    logic             below;

    assign wrap = step && (cnt_q == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= wrap;
            if (step)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign below        = (cnt_q < act_cfg.cval);
    assign pwm_out      = act_cfg.pol ? below : !below;
    assign period_start = strobe_q;

    // R10
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        period_start |=> !period_start);

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (step && cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == '0 && period_start));

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt_q));

endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
    import bl_pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        slow_en,
    input  logic        sys_en,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [15:0] wr_data,
    output logic        pwm_out,
    output logic        period_start
);

    pwm_cfg_t act_cfg;
    src_sel_t src_sel;
    logic     wrap;
    logic     step;

    bl_pwm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .wrap    (wrap),
        .act_cfg (act_cfg),
        .src_sel (src_sel)
    );

    bl_pwm_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .slow_en (slow_en),
        .sys_en  (sys_en),
        .src_sel (src_sel),
        .psc     (act_cfg.psc),
        .wrap    (wrap),
        .step    (step)
    );

    bl_pwm_counter u_cnt (
        .clk          (clk),
        .rst          (rst),
        .step         (step),
        .act_cfg      (act_cfg),
        .wrap         (wrap),
        .pwm_out      (pwm_out),
        .period_start (period_start)
    );

endmodule

// File: tb/bl_pwm_top_tb.sv
module bl_pwm_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_en = 1'b0;
    logic        sys_en = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        pwm_out;
    logic        period_start;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    localparam int LIMIT = 40000;
    localparam int SLOW_DIV = 4;

    bl_pwm_top u_dut (
        .clk(clk), .rst(rst), .slow_en(slow_en), .sys_en(sys_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pwm_out(pwm_out), .period_start(period_start)
    );

    always #5 clk = ~clk;

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            slow_en = (ph == SLOW_DIV - 1);
            ph = (ph + 1) % SLOW_DIV;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_strobe();
        int g = 0;
        @(negedge clk);
        while (!period_start && g < LIMIT) begin
            @(negedge clk);
            g++;
        end
    endtask

    // starts on a strobe cycle, ends on the next strobe cycle
    task automatic measure(output int len, output int highs);
        len = 0; highs = 0;
        do begin
            highs += int'(pwm_out);
            len++;
            @(negedge clk);
        end while (!period_start && len < LIMIT);
    endtask

    function automatic logic [15:0] cfg_word(input int cv, input int pol, input int n);
        // junk in bits 7:5 and 3 must be ignored (R5)
        return {8'(cv), 3'b101, 1'(pol), 1'b1, 3'(n)};
    endfunction

    initial begin
        repeat (30 * 20000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int len, hi, en, n, cvs[9];
        cvs = '{0, 1, 2, 3, 127, 128, 200, 254, 255};

        // R1 reset state
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b1, "R1 pwm_out in reset", pwm_out, 1);
        check(period_start == 1'b0, "R1 strobe in reset", period_start, 0);
        rst = 1'b0;
        @(negedge clk);
        check(pwm_out == 1'b1, "R1 pwm_out after reset", pwm_out, 1);
        check(period_start == 1'b0, "R1 strobe after reset", period_start, 0);

        // R8 select system enable
        write_reg(1'b1, 16'h0001);

        // R6 R7 R2 R3: prescale sweep, compare 64, polarity 1
        for (int k = 0; k <= 7; k++) begin
            n = (k > 6) ? 6 : k;
            write_reg(1'b0, cfg_word(64, 1, k));
            wait_strobe();
            measure(len, hi);
            check(len == (256 << n), (k == 7) ? "R7 period" : "R6 period", len, 256 << n);
            check(hi == (64 << n), (k == 7) ? "R7 high time" : "R6 high time", hi, 64 << n);
        end

        // R3 R4 R5: duty sweep, N=0
        for (int p = 0; p <= 1; p++) begin
            for (int i = 0; i < 9; i++) begin
                write_reg(1'b0, cfg_word(cvs[i], p, 0));
                wait_strobe();
                measure(len, hi);
                en = p ? cvs[i] : 256 - cvs[i];
                check(len == 256, "R2 period N=0", len, 256);
                check(hi == en, p ? "R3 high time" : "R4 high time", hi, en);
            end
        end

        // R10: strobe lasts one cycle
        wait_strobe();
        @(negedge clk);
        check(period_start == 1'b0, "R10 strobe width", period_start, 0);

        // R8: slow source, N=1, compare 100
        write_reg(1'b1, 16'h0000);
        write_reg(1'b0, cfg_word(100, 1, 1));
        wait_strobe();
        wait_strobe();
        measure(len, hi);
        check(len == 256 * 2 * SLOW_DIV, "R8 slow period", len, 256 * 2 * SLOW_DIV);
        check(hi == 100 * 2 * SLOW_DIV, "R8 slow high time", hi, 100 * 2 * SLOW_DIV);

        // R9: mid-period rewrite must wait for the wrap
        write_reg(1'b1, 16'h0001);
        write_reg(1'b0, cfg_word(10, 1, 0));
        wait_strobe();
        wait_strobe();
        repeat (100) @(negedge clk);
        write_reg(1'b0, cfg_word(200, 1, 0));
        hi = 0;
        begin
            int g = 0;
            while (!period_start && g < LIMIT) begin
                hi += int'(pwm_out);
                @(negedge clk);
                g++;
            end
        end
        check(hi == 0, "R9 old setting kept", hi, 0);
        measure(len, hi);
        check(hi == 200, "R9 new setting applied", hi, 200);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule